// File: doc/BRIEF.md
# Register, ALU and Flag Execute Datapath

This block is the execute datapath of a 16-bit load/store processor. It holds eight general registers, each 16 bits wide. Two combinational read ports are addressed by fields of the instruction word. A small ALU sits after the read ports, and three status flags record the sign class of the last value written. It also produces a branch-enable bit by masking the flags with three instruction bits. A sequencer outside the block decodes the opcode and drives the strobes. Memory, the program counter and bus multiplexing also sit outside the block.

The sequencer presents the low twelve bits of the instruction and an ALU operation code. It then places the value to be written on `wr_bus`. That value may be the ALU result or data from elsewhere. On a rising clock edge, `reg_ld` writes that value into the destination register. In the same way, `cc_ld` reloads the flags from the sign class of that value. All values are two's-complement integers.

Top module: `ex_datapath`

## Requirements
- R1: After reset (`rst_n` low), every register reads 0. Only the zero flag is set, so `br_en` is 1 when `instr_lo[10]` is 1 and 0 when only `instr_lo[11]` or only `instr_lo[9]` is 1.
- R2: On a rising edge with `reg_ld` high, `wr_bus` is stored in the destination register. With `reg_ld` low, no register changes.
- R3: The destination register is `instr_lo[11:9]` when `dst_link` is 0, and register 7 when `dst_link` is 1.
- R4: `sr1_val` is the register addressed by `instr_lo[8:6]` when `sr1_hi` is 0, and by `instr_lo[11:9]` when `sr1_hi` is 1.
- R5: The second ALU operand comes from one of two places, chosen by `instr_lo[5]`. When `instr_lo[5]` is 0, it is the register addressed by `instr_lo[2:0]`. When `instr_lo[5]` is 1, it is `instr_lo[4:0]` sign-extended to 16 bits.
- R6: `alu_y` depends on `alu_op`. Code 0 gives `sr1_val` plus operand B, modulo 2^16. Code 1 gives the bitwise AND. Code 2 gives the bitwise complement of `sr1_val`. Code 3 gives `sr1_val` unchanged.
- R7: On a rising edge with `cc_ld` high, exactly one flag becomes set. The negative flag is set when `wr_bus[15]` is 1. The zero flag is set when `wr_bus` is 0. The positive flag is set otherwise. With `cc_ld` low, the flags hold.
- R8: `br_en` = (`instr_lo[11]` AND negative) OR (`instr_lo[10]` AND zero) OR (`instr_lo[9]` AND positive). This makes it 0 for mask 000 and 1 for mask 111.
- R9: The flags follow `wr_bus` and not `alu_y`. They are also updated when `cc_ld` is high and `reg_ld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_lo | input | 12 | Low instruction bits: register fields, immediate, flag mask |
| sr1_hi | input | 1 | First source from bits 11:9 instead of 8:6 |
| dst_link | input | 1 | Force the destination to register 7 |
| alu_op | input | 2 | 0 add, 1 and, 2 not, 3 pass |
| reg_ld | input | 1 | Register write strobe |
| cc_ld | input | 1 | Flag update strobe |
| wr_bus | input | 16 | Value to write and to classify |
| alu_y | output | 16 | ALU result |
| sr1_val | output | 16 | First source register value |
| br_en | output | 1 | Branch enable |

## Verification
The flags can only be seen through `br_en`, and only while the right mask bits are present. The hardest case to bring about is a flag update that disagrees with the ALU output. The bench produces it by loading flags with `cc_ld` alone while `alu_y` carries an unrelated value. It also writes registers with `reg_ld` alone and checks that the flags held. On every cycle it compares `br_en` against a model of the flags, so each such change is observed on the next step under a varying mask.

// File: rtl/ex_dp_pkg.sv
package ex_dp_pkg;
  localparam int DATA_W = 16;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 5;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_AND  = 2'd1,
    OP_NOT  = 2'd2,
    OP_PASS = 2'd3
  } alu_op_e;

  function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] alu_eval(input alu_op_e op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_AND:  return a & b;
      OP_NOT:  return ~a;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/ex_regfile.sv
module ex_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import ex_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/ex_cond.sv
module ex_cond #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cc_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        mask,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p,
  output logic              br_en
);
  logic is_neg, is_zero;

  assign is_neg  = wdata[DATA_W-1];
  assign is_zero = (wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b1;
      flag_p <= 1'b0;
    end else if (cc_we) begin
      flag_n <= is_neg;
      flag_z <= is_zero;
      flag_p <= !is_neg && !is_zero;
    end
  end

  assign br_en = |(mask & {flag_n, flag_z, flag_p});
endmodule

// File: rtl/ex_datapath.sv
module ex_datapath
  import ex_dp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] instr_lo,
  input  logic        sr1_hi,
  input  logic        dst_link,
  input  logic [1:0]  alu_op,
  input  logic        reg_ld,
  input  logic        cc_ld,
  input  logic [15:0] wr_bus,
  output logic [15:0] alu_y,
  output logic [15:0] sr1_val,
  output logic        br_en
);
  logic [RIDX_W-1:0] fld_hi, fld_mid, fld_lo;
  logic [RIDX_W-1:0] sr1_idx, dst_idx;
  logic [DATA_W-1:0] sr2_val, opnd_b;
  logic              use_imm;
  logic              cc_n, cc_z, cc_p;

  assign fld_hi  = instr_lo[11:9];
  assign fld_mid = instr_lo[8:6];
  assign fld_lo  = instr_lo[2:0];
  assign use_imm = instr_lo[5];

  assign sr1_idx = sr1_hi   ? fld_hi : fld_mid;
  assign dst_idx = dst_link ? RIDX_W'(NREG-1) : fld_hi;

  ex_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_ld),
    .waddr   (dst_idx),
    .wdata   (wr_bus),
    .raddr_a (sr1_idx),
    .raddr_b (fld_lo),
    .rdata_a (sr1_val),
    .rdata_b (sr2_val)
  );

  assign opnd_b = use_imm ? sext_imm(instr_lo[IMM_W-1:0]) : sr2_val;

  ex_alu #(.DATA_W(DATA_W)) u_alu (
    .op (alu_op_e'(alu_op)),
    .a  (sr1_val),
    .b  (opnd_b),
    .y  (alu_y)
  );

  ex_cond #(.DATA_W(DATA_W)) u_cc (
    .clk    (clk),
    .rst_n  (rst_n),
    .cc_we  (cc_ld),
    .wdata  (wr_bus),
    .mask   (fld_hi),
    .flag_n (cc_n),
    .flag_z (cc_z),
    .flag_p (cc_p),
    .br_en  (br_en)
  );
endmodule

// File: rtl/ex_datapath_chk.sv
module ex_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] instr_lo,
  input logic [1:0]  alu_op,
  input logic        cc_ld,
  input logic [15:0] wr_bus,
  input logic [15:0] alu_y,
  input logic [15:0] sr1_val,
  input logic        br_en,
  input logic        cc_n,
  input logic        cc_z,
  input logic        cc_p
);
  AST_CC_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cc_n, cc_z, cc_p}) == 1); // R7
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_ld |=> $stable({cc_n, cc_z, cc_p})); // R7
  AST_CC_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cc_ld |=> (cc_n == $past(wr_bus[15]) && cc_z == ($past(wr_bus) == 16'h0))); // R9
  AST_BR_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_lo[11:9] == 3'b000) |-> !br_en); // R8
  AST_BR_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_lo[11:9] == 3'b111) |-> br_en); // R8
  AST_ALU_NOT: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'd2) |-> (alu_y == ~sr1_val)); // R6
  AST_ALU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'd3) |-> (alu_y == sr1_val)); // R6
endmodule

bind ex_datapath ex_datapath_chk u_chk (.*);

// File: tb/ex_datapath_tb.sv
module ex_datapath_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] instr_lo = '0;
  logic        sr1_hi = 1'b0, dst_link = 1'b0, reg_ld = 1'b0, cc_ld = 1'b0;
  logic [1:0]  alu_op = '0;
  logic [15:0] wr_bus = '0;
  logic [15:0] alu_y, sr1_val;
  logic        br_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] m_reg [8];
  logic m_n, m_z, m_p;

  always #5 clk = ~clk;

  ex_datapath u_dut (.*);

  function automatic logic [15:0] f_imm(input logic [4:0] v);
    return 16'($signed(v));
  endfunction

  function automatic logic [15:0] f_alu(input logic [1:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    if (op == 2'd0) return 16'(a + b);
    if (op == 2'd1) return a & b;
    if (op == 2'd2) return a ^ 16'hFFFF;
    return a;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic [11:0] ins, input bit s1,
                      input bit dl, input logic [1:0] op, input bit rl, input bit cl,
                      input logic [15:0] bus);
    logic [15:0] a, b;
    logic        be;
    instr_lo = ins; sr1_hi = s1; dst_link = dl; alu_op = op;
    reg_ld = rl; cc_ld = cl; wr_bus = bus;
    #1;
    a  = s1 ? m_reg[ins[11:9]] : m_reg[ins[8:6]];
    b  = ins[5] ? f_imm(ins[4:0]) : m_reg[ins[2:0]];
    be = (ins[11] & m_n) | (ins[10] & m_z) | (ins[9] & m_p);
    chk(tag, "sr1_val", sr1_val, a);
    chk(tag, "alu_y", alu_y, f_alu(op, a, b));
    chk(tag, "br_en", 16'(br_en), 16'(be));
    @(posedge clk);
    if (rl) m_reg[dl ? 3'd7 : ins[11:9]] = bus;
    if (cl) begin
      m_n = bus[15];
      m_z = (bus == 16'h0);
      m_p = !bus[15] && (bus != 16'h0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_n = 0; m_z = 1; m_p = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents and zero flag
    for (int i = 0; i < 8; i++) step("R1", {3'b010, 3'(i), 6'b000000}, 0, 0, 2'd3, 0, 0, 0);
    step("R1", 12'b100_000_000000, 0, 0, 2'd3, 0, 0, 0);
    step("R1", 12'b001_000_000000, 0, 0, 2'd3, 0, 0, 0);
    // R2: write with strobe, no write without
    step("R2", 12'b011_000_000000, 0, 0, 2'd0, 1, 1, 16'h8001);
    step("R2", 12'b100_011_000000, 0, 0, 2'd3, 0, 0, 16'h5555);
    step("R2", 12'b100_100_000000, 0, 0, 2'd3, 0, 0, 0);
    // R3: forced link destination
    step("R3", 12'b010_000_000000, 0, 1, 2'd3, 1, 0, 16'h1234);
    step("R3", 12'b010_111_000000, 0, 0, 2'd3, 0, 0, 0);
    // R4: first source from high field
    step("R4", 12'b111_000_000011, 1, 0, 2'd3, 0, 0, 0);
    step("R4", 12'b011_111_000000, 1, 0, 2'd3, 0, 0, 0);
    // R9: flags from bus only, alu_y unrelated
    step("R9", 12'b000_111_000000, 0, 0, 2'd3, 0, 1, 16'h0000);
    step("R9", 12'b010_111_000000, 0, 0, 2'd3, 0, 1, 16'h7FFF);
    step("R9", 12'b001_111_000000, 0, 0, 2'd3, 0, 0, 0);
    // R7: register write without cc_ld keeps flags
    step("R7", 12'b101_000_000000, 0, 0, 2'd0, 1, 0, 16'hF000);
    step("R7", 12'b001_101_000000, 0, 0, 2'd3, 0, 0, 0);
    step("R7", 12'b100_000_000000, 0, 0, 2'd3, 0, 1, 16'h8000);
    // R5: immediate extremes and register operand
    step("R5", 12'b000_111_110000, 0, 0, 2'd0, 0, 0, 0);
    step("R5", 12'b000_111_101111, 0, 0, 2'd0, 0, 0, 0);
    step("R5", 12'b000_111_000011, 0, 0, 2'd0, 0, 0, 0);
    // R6: each operation
    step("R6", 12'b000_101_000111, 0, 0, 2'd1, 0, 0, 0);
    step("R6", 12'b000_101_000111, 0, 0, 2'd2, 0, 0, 0);
    step("R6", 12'b000_011_110101, 0, 0, 2'd1, 0, 0, 0);
    // R8: empty and full masks
    step("R8", 12'b000_011_000000, 0, 0, 2'd3, 0, 0, 0);
    step("R8", 12'b111_011_000000, 0, 0, 2'd3, 0, 0, 0);
    // R2 R6 R7 R8: random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] bus;
      bus = 16'($urandom);
      if ($urandom_range(0, 7) == 0) bus = 16'h0;
      step("R2/R6/R7/R8 random", 12'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), bus);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule